// File: doc/BRIEF.md
# Indexed Register Window Peripheral

This block lets an 8-bit processor with a 6502-style bus reach a set of 32 byte-wide internal registers through just two bus offsets. The low offset is a control port. Writing to it loads the index of the target register. Reading it returns a status byte. The high offset is a data port. It reads or writes whichever register the index currently points at. Reading or writing the data port never changes the index.

An accepted data write does three things:
- It updates the register.
- It sets a busy flag.
- It sends a one-cycle request to a back-end engine. The request carries the index, the byte written and the 16-bit pair that contains that register.

Adjacent even/odd registers form the low and high bytes of 16-bit coordinate values. These are loaded one byte at a time. The back end clears busy with a done pulse. Software polls status for not-busy before each data write. The back end can also deposit a result byte into any register, which raises a read-pending flag.

A bus access happens once per phi2-high phase in which chip select is high. The block samples the access on the system clock and applies its effects when the phase ends.

Top module: `regwin_periph`

## Requirements
- R1: After reset the index is 0, all registers read 0, the status byte is 0, `req_o` is low and `data_oe_o` is low.
- R2: A read at offset 0 returns status. Bit 0 is busy, bit 1 is read-pending, bit 2 is write-error, and bits 7..3 are 0.
- R3: A write at offset 0 loads the index from data bits 4..0. Bits 7..5 are ignored.
- R4: A read or write at offset 1 accesses the register selected by the index, and the index is unchanged afterwards.
- R5: An accepted write at offset 1 sets busy. A `done_i` pulse clears busy.
- R6: An accepted write at offset 1 produces a single-cycle `req_o`. With it come `req_idx_o` (the index), `req_data_o` (the byte written) and `req_pair_o`. `req_pair_o` holds the updated register with odd index `idx|1` in bits 15..8 and the one with even index `idx&~1` in bits 7..0.
- R7: A write at offset 1 while busy is ignored: the register is unchanged and no request is sent. It sets the write-error bit, which stays set until the end of the next status read. That read still returns the bit as 1.
- R8: A back-end write (`be_we_i`) stores `be_data_i` into register `be_idx_i` and sets read-pending. A CPU read at offset 1 clears read-pending.
- R9: `data_oe_o` is high only while `cs_i`, `phi2_i` and `rw_i` are all high. A phase with `cs_i` low has no effect on state.
- R10: An access takes effect on the clock edge after `phi2_i` falls. Write data is the value sampled on the last clock edge of the phi2-high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than phi2 |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| phi2_i | input | 1 | Bus phase 2 clock level |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 1 | Offset: 0 control/status, 1 data |
| data_i | input | 8 | Write data from the bus |
| data_o | output | 8 | Read data toward the bus |
| data_oe_o | output | 1 | Drive enable for the bus pads |
| req_o | output | 1 | One-cycle request to the back end |
| req_idx_o | output | 5 | Register index of the request |
| req_data_o | output | 8 | Byte written with the request |
| req_pair_o | output | 16 | 16-bit pair containing the written register |
| done_i | input | 1 | Back end finished; clears busy |
| be_we_i | input | 1 | Back-end register write strobe |
| be_idx_i | input | 5 | Back-end write index |
| be_data_i | input | 8 | Back-end write data |

## Verification
Every one of the 32 indices is selected with different junk in bits 7..5. Each is then written with a value computed from its index, so that an index-decode or bit-masking fault lands a value in the wrong register or drops it. Writing even indices before their odd partners shows whether `req_pair_o` assembles the halves in the right order from fresh data. A full read-back pass after all the writes catches any write that overwrote a neighbour. Separate sequences cover three things:
- A write while busy, followed by two status reads. This separates an ignored write from an accepted one, and sticky clearing from no clearing.
- A deselected read phase, which must not clear the error bit.
- A back-end deposit, which exercises the pending flag's set and clear.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int unsigned STAT_BUSY = 0;
  localparam int unsigned STAT_PEND = 1;
  localparam int unsigned STAT_ERR  = 2;
endpackage

// File: rtl/regwin_bus_if.sv
// Samples one bus access per phi2-high phase; commit pulses after the phase ends.
module regwin_bus_if #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              phi2_i,
  input  logic              rw_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              oe_o,
  output logic              commit_o,
  output logic              c_rd_o,
  output logic              c_addr_o,
  output logic [DATA_W-1:0] c_data_o
);
  logic strobe, strobe_q;

  assign strobe   = cs_i & phi2_i;
  assign oe_o     = strobe & rw_i;
  assign commit_o = strobe_q & ~strobe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      c_rd_o   <= 1'b1;
      c_addr_o <= 1'b0;
      c_data_o <= '0;
    end else begin
      strobe_q <= strobe;
      if (strobe) begin
        c_rd_o   <= rw_i;
        c_addr_o <= addr_i;
        c_data_o <= data_i;
      end
    end
  end

  // R9: pads are driven only inside a selected read phase
  always_comb begin
    if (rst_ni) assert_oe_qualified_R9: assert (!oe_o || (cs_i && phi2_i && rw_i));
  end
endmodule

// File: rtl/regwin_regfile.sv
module regwin_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_we_i,
  input  logic [IDX_W-1:0]    cpu_idx_i,
  input  logic [DATA_W-1:0]   cpu_data_i,
  input  logic                be_we_i,
  input  logic [IDX_W-1:0]    be_idx_i,
  input  logic [DATA_W-1:0]   be_data_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [IDX_W-1:0]    pair_idx_i,
  output logic [2*DATA_W-1:0] pair_data_o
);
  localparam int unsigned NREG = 1 << IDX_W;

  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs[g] <= '0;
      else if (cpu_we_i && cpu_idx_i == IDX_W'(g))  regs[g] <= cpu_data_i;  // CPU wins a collision
      else if (be_we_i && be_idx_i == IDX_W'(g))    regs[g] <= be_data_i;
    end
  end

  assign rd_data_o   = regs[rd_idx_i];
  assign pair_data_o = {regs[{pair_idx_i[IDX_W-1:1], 1'b1}],
                        regs[{pair_idx_i[IDX_W-1:1], 1'b0}]};
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              c_rd_i,
  input  logic              c_addr_i,
  input  logic [DATA_W-1:0] c_data_i,
  input  logic              done_i,
  input  logic              be_we_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] status_o,
  output logic              cpu_we_o,
  output logic              req_o,
  output logic [IDX_W-1:0]  req_idx_o,
  output logic [DATA_W-1:0] req_data_o
);
  logic busy, pend, err;
  logic idx_wr, stat_rd, data_rd, data_wr, rejected;

  assign idx_wr   = commit_i & ~c_rd_i & ~c_addr_i;
  assign stat_rd  = commit_i &  c_rd_i & ~c_addr_i;
  assign data_rd  = commit_i &  c_rd_i &  c_addr_i;
  assign data_wr  = commit_i & ~c_rd_i &  c_addr_i;
  assign cpu_we_o = data_wr & ~busy;
  assign rejected = data_wr &  busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o      <= '0;
      busy       <= 1'b0;
      pend       <= 1'b0;
      err        <= 1'b0;
      req_o      <= 1'b0;
      req_idx_o  <= '0;
      req_data_o <= '0;
    end else begin
      req_o <= cpu_we_o;
      if (idx_wr) idx_o <= c_data_i[IDX_W-1:0];
      if (cpu_we_o) begin
        busy       <= 1'b1;
        req_idx_o  <= idx_o;
        req_data_o <= c_data_i;
      end else if (done_i) begin
        busy <= 1'b0;
      end
      if (be_we_i)      pend <= 1'b1;
      else if (data_rd) pend <= 1'b0;
      if (rejected)     err <= 1'b1;
      else if (stat_rd) err <= 1'b0;
    end
  end

  always_comb begin
    status_o            = '0;
    status_o[STAT_BUSY] = busy;
    status_o[STAT_PEND] = pend;
    status_o[STAT_ERR]  = err;
  end

  assert_busy_on_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_o |=> busy);
  assert_done_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !cpu_we_o) |=> !busy);
  assert_req_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  assert_req_with_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> busy);
  assert_idx_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && c_addr_i) |=> $stable(idx_o));
  assert_reject_sets_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rejected |=> (err && !req_o));
endmodule

// File: rtl/regwin_periph.sv
module regwin_periph #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_i,
  input  logic                phi2_i,
  input  logic                rw_i,
  input  logic                addr_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [DATA_W-1:0]   data_o,
  output logic                data_oe_o,
  output logic                req_o,
  output logic [IDX_W-1:0]    req_idx_o,
  output logic [DATA_W-1:0]   req_data_o,
  output logic [2*DATA_W-1:0] req_pair_o,
  input  logic                done_i,
  input  logic                be_we_i,
  input  logic [IDX_W-1:0]    be_idx_i,
  input  logic [DATA_W-1:0]   be_data_i
);
  logic              commit, c_rd, c_addr, cpu_we;
  logic [DATA_W-1:0] c_data, status, rd_data;
  logic [IDX_W-1:0]  idx;

  regwin_bus_if #(.DATA_W(DATA_W)) u_bus (
    .clk_i, .rst_ni, .cs_i, .phi2_i, .rw_i, .addr_i, .data_i,
    .oe_o(data_oe_o), .commit_o(commit), .c_rd_o(c_rd), .c_addr_o(c_addr), .c_data_o(c_data)
  );

  regwin_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .commit_i(commit), .c_rd_i(c_rd), .c_addr_i(c_addr), .c_data_i(c_data),
    .done_i, .be_we_i, .idx_o(idx), .status_o(status), .cpu_we_o(cpu_we),
    .req_o, .req_idx_o, .req_data_o
  );

  regwin_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
    .clk_i, .rst_ni, .cpu_we_i(cpu_we), .cpu_idx_i(idx), .cpu_data_i(c_data),
    .be_we_i, .be_idx_i, .be_data_i, .rd_idx_i(idx), .rd_data_o(rd_data),
    .pair_idx_i(req_idx_o), .pair_data_o(req_pair_o)
  );

  assign data_o = addr_i ? rd_data : status;
endmodule

// File: tb/regwin_periph_bench.sv
module regwin_periph_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cs_i = 1'b0, phi2_i = 1'b0, rw_i = 1'b1, addr_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic [7:0]  data_o;
  logic        data_oe_o, req_o, done_i = 1'b0, be_we_i = 1'b0;
  logic [4:0]  req_idx_o, be_idx_i = '0;
  logic [7:0]  req_data_o, be_data_i = '0;
  logic [15:0] req_pair_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [32];
  logic        r_seen;
  logic [4:0]  r_idx;
  logic [7:0]  r_data, rd;
  logic [15:0] r_pair;

  regwin_periph u_regwin_periph (.*);

  always #5 clk_i = ~clk_i;

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // One bus phase; req_* captured on the negedge after the commit edge.
  task automatic bus(input bit sel, input bit rw, input bit a, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk_i);
    cs_i = sel; rw_i = rw; addr_i = a; data_i = d;
    phi2_i = 1'b1;
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i);
    q = data_o;
    chk(data_oe_o == (sel && rw), "R9 oe during phase", data_oe_o, sel && rw);
    phi2_i = 1'b0; cs_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    r_seen = req_o; r_idx = req_idx_o; r_data = req_data_o; r_pair = req_pair_o;
    rw_i = 1'b1;
    @(negedge clk_i);
    chk(!req_o, "R6 req single cycle", req_o, 0);
  endtask

  task automatic pulse_done();
    @(negedge clk_i); done_i = 1'b1;
    @(negedge clk_i); done_i = 1'b0;
  endtask

  initial begin
    logic [7:0] q;
    for (int i = 0; i < 32; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_o == 0 && data_oe_o == 0, "R1 reset outputs", {req_o, data_oe_o}, 0);
    bus(1, 1, 0, 8'h00, q); chk(q == 8'h00, "R1 reset status", q, 0);
    bus(1, 1, 1, 8'h00, q); chk(q == 8'h00, "R1 reset reg0", q, 0);

    // sweep all indices with junk in bits 7..5
    for (int i = 0; i < 32; i++) begin
      logic [7:0] v;
      v = 8'(i * 37 + 11) ^ 8'h5A;
      bus(1, 0, 0, {3'(i + 5), 5'(i)}, q);           // R3 select
      chk(!r_seen, "R3 index write no req", r_seen, 0);
      bus(1, 0, 1, v, q);
      mem[i] = v;
      chk(r_seen, "R6 req fired", r_seen, 1);
      chk(r_idx == 5'(i) && r_data == v, "R6 req idx/data", {r_idx, r_data}, {5'(i), v});
      chk(r_pair == {mem[i | 1], mem[i & 30]}, "R6 req pair", r_pair, {mem[i | 1], mem[i & 30]});
      bus(1, 1, 0, 8'h00, q); chk(q == 8'h01, "R5 busy after write", q, 8'h01);
      pulse_done();
      bus(1, 1, 0, 8'h00, q); chk(q == 8'h00, "R2 R5 idle after done", q, 8'h00);
      bus(1, 1, 1, 8'h00, q); chk(q == v, "R4 read back same index", q, v);
    end

    // full read-back
    for (int i = 0; i < 32; i++) begin
      bus(1, 0, 0, 8'(i), q);
      bus(1, 1, 1, 8'h00, q);
      chk(q == mem[i], "R4 read-back pass", q, mem[i]);
    end

    // write while busy
    bus(1, 0, 0, 8'd3, q);
    bus(1, 0, 1, 8'hA5, q); mem[3] = 8'hA5;
    bus(1, 0, 1, 8'h3C, q);
    chk(!r_seen, "R7 rejected write no req", r_seen, 0);
    bus(0, 1, 0, 8'h00, q);                         // deselected read phase
    chk(!r_seen, "R9 deselected no req", r_seen, 0);
    bus(1, 1, 0, 8'h00, q); chk(q == 8'h05, "R7 R9 err set, not cleared by deselect", q, 8'h05);
    bus(1, 1, 0, 8'h00, q); chk(q == 8'h01, "R7 err cleared by status read", q, 8'h01);
    pulse_done();
    bus(1, 1, 1, 8'h00, q); chk(q == 8'hA5, "R7 rejected write ignored", q, 8'hA5);
    bus(0, 0, 0, 8'h1F, q);                         // deselected write: index must stay 3
    bus(1, 1, 1, 8'h00, q); chk(q == 8'hA5, "R9 deselected write ignored", q, 8'hA5);

    // back-end deposit
    @(negedge clk_i); be_we_i = 1'b1; be_idx_i = 5'd7; be_data_i = 8'h99;
    @(negedge clk_i); be_we_i = 1'b0; mem[7] = 8'h99;
    bus(1, 1, 0, 8'h00, q); chk(q == 8'h02, "R8 pending set", q, 8'h02);
    bus(1, 0, 0, 8'd7, q);
    bus(1, 1, 1, 8'h00, q); chk(q == 8'h99, "R8 deposited value", q, 8'h99);
    bus(1, 1, 0, 8'h00, q); chk(q == 8'h00, "R8 pending cleared", q, 8'h00);

    // R10: a write phase with data changing mid-phase commits the late value
    bus(1, 0, 0, 8'd6, q);
    @(negedge clk_i); cs_i = 1; rw_i = 0; addr_i = 1; data_i = 8'h11; phi2_i = 1;
    @(negedge clk_i); data_i = 8'h77;
    chk(!req_o, "R10 no effect before phi2 falls", req_o, 0);
    @(negedge clk_i); phi2_i = 0; cs_i = 0;
    @(negedge clk_i); chk(req_o && req_data_o == 8'h77, "R10 late data committed", req_data_o, 8'h77);
    chk(req_pair_o == {mem[7], 8'h77}, "R10 R6 pair order", req_pair_o, {mem[7], 8'h77});
    rw_i = 1;
    pulse_done();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule